// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Registered Feedback

This block is a field-programmable two-level logic array that becomes a programmable state machine through a clocked feedback loop. Every external input and every feedback input passes through its own true/complement splitter. A personality-programmed AND plane forms product terms from those lines, and a personality-programmed OR plane sums the terms into columns. The low columns drive the external outputs combinationally. The remaining columns feed a bank of state bits, two columns per bit.

Each state bit is either a plain D register or a J-K element, chosen per bit by a mode word. The state bits are not wired straight back into the array. They pass through a separate connection matrix, the routing plane, and each feedback input of the array is the OR of whichever state bits are connected to it. A build-time option replaces the routing plane with a fixed one-to-one connection.

Because the loop always crosses a register, the array never sees a value produced in the same cycle, and no combinational loop can form. All personality (AND rows, OR rows, routing rows and the mode word) is written one row per clock through a simple write port. The active-low reset is asynchronous and is expected to be released synchronously by the surrounding logic. It clears both the personality and the state. A separate synchronous clear input clears only the state.

Top module: `sop_seq_array`

## Requirements
- R1: While reset is asserted and after its release, before any write, all personality and state are zero, so every product term is inhibited and `dout` is zero for any `din`.
- R2: An AND row holds two bits per array variable `v`, at bits `[2v+1:2v]`. Bit `2v` enables the true line and bit `2v+1` enables the complement line. Code 11 means the variable is ignored, 01 selects true, 10 selects complement, and 00 forces the term to 0. Variables `0..N_IN-1` are `din` bits and variables `N_IN..N_IN+N_FBIN-1` are the feedback inputs.
- R3: OR column `c` is the OR of every term whose OR row has bit `c` set. `dout[k]` is column `k` in the same cycle, with no register in the path. A column with no active term is 0.
- R4: A write with `wr_en`=1 is captured at the rising edge and affects the array from that edge on, not before. `wr_sel` chooses the target: 0 = AND row `wr_addr`, 1 = OR row `wr_addr` (data bits `[N_OUT+2*N_ST-1:0]`), 2 = routing row `wr_addr` (data bits `[N_ST-1:0]`), 3 = mode word (data bits `[N_ST-1:0]`).
- R5: With the routing plane in use, feedback input `j` is the OR of the state bits selected by routing row `j`. It is 0 when no bit is selected.
- R6: A state bit in D mode (mode bit 0) loads column `N_OUT+2i` at each rising edge. The array sees the new value only after that edge.
- R7: A state bit in J-K mode (mode bit 1) takes J from column `N_OUT+2i` and K from column `N_OUT+2i+1`. It holds for J=0,K=0, clears for J=0,K=1, sets for J=1,K=0 and toggles for J=1,K=1.
- R8: `clr`=1 at a rising edge clears every state bit and leaves all personality unchanged.
- R9: With `FIXED_FB`=1, feedback input `j` is state bit `j` directly, and routing-row writes have no effect on behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of the state bits |
| din | input | N_IN | External array inputs |
| dout | output | N_OUT | External outputs, combinational from the OR plane |
| wr_en | input | 1 | Personality write strobe |
| wr_sel | input | 2 | Plane select: 0 AND, 1 OR, 2 routing, 3 mode |
| wr_addr | input | AW | Row address within the selected plane |
| wr_data | input | DW | Row contents, right-aligned |

## Verification
The bench builds two copies with `N_IN`=4, `N_OUT`=4, `N_ST`=4, `N_FBIN`=4 and `N_TERM`=12. The first copy has the programmable routing plane. Its 16-bit AND rows allow every literal code to be exercised on both external and feedback variables. The four state bits allow a D-mode toggler, an OR of two routed bits and a full J-K walk to be held in separate bits. The second copy sets `FIXED_FB`=1. In that copy a routing write that would cut the loop is shown to be ignored, because the fed-back value still reaches an output.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    PL_AND   = 2'd0,
    PL_OR    = 2'd1,
    PL_ROUTE = 2'd2,
    PL_MODE  = 2'd3
  } plane_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_VAR  = 8,
  parameter int N_TERM = 12,
  parameter int AW     = 4,
  localparam int RW    = 2 * N_VAR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [RW-1:0]     wr_row,
  input  logic [N_VAR-1:0]  vars,
  output logic [N_TERM-1:0] terms
);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    localparam logic [AW-1:0] IDX = AW'(t);
    logic [RW-1:0] row_q;
    logic          row_en;
    logic          hit;

    assign row_en = wr_en && (wr_addr == IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (row_en) begin
        row_q <= wr_row;
      end
    end

    // Per variable: selected true line OR selected complement line, then AND across variables.
    always_comb begin
      hit = 1'b1;
      for (int v = 0; v < N_VAR; v++) begin
        hit = hit & ((row_q[2*v] & vars[v]) | (row_q[2*v+1] & ~vars[v]));
      end
    end

    assign terms[t] = hit;
  end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERM = 12,
  parameter int N_OR   = 12,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [N_OR-1:0]   wr_row,
  input  logic [N_TERM-1:0] terms,
  output logic [N_OR-1:0]   cols
);

  logic [N_OR-1:0] contrib [N_TERM];

  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    localparam logic [AW-1:0] IDX = AW'(t);
    logic [N_OR-1:0] row_q;
    logic            row_en;

    assign row_en = wr_en && (wr_addr == IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (row_en) begin
        row_q <= wr_row;
      end
    end

    assign contrib[t] = terms[t] ? row_q : '0;
  end

  always_comb begin
    cols = '0;
    for (int t = 0; t < N_TERM; t++) begin
      cols = cols | contrib[t];
    end
  end

  // R3: no active product term means every column is low.
  p_idle_cols_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (terms == '0) |-> (cols == '0));

endmodule

// File: rtl/sop_fb_route.sv
module sop_fb_route #(
  parameter int N_ST     = 4,
  parameter int N_FBIN   = 4,
  parameter bit FIXED_FB = 1'b0,
  parameter int AW       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [N_ST-1:0]   wr_row,
  input  logic [N_ST-1:0]   st,
  output logic [N_FBIN-1:0] fb
);

  logic [N_FBIN-1:0] routed;
  logic [N_FBIN-1:0] direct;

  for (genvar j = 0; j < N_FBIN; j++) begin : g_line
    localparam logic [AW-1:0] IDX = AW'(j);
    logic [N_ST-1:0] row_q;
    logic            row_en;

    assign row_en = wr_en && (wr_addr == IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (row_en) begin
        row_q <= wr_row;
      end
    end

    assign routed[j] = |(row_q & st);

    if (j < N_ST) begin : g_dir
      assign direct[j] = st[j];
    end else begin : g_nodir
      assign direct[j] = 1'b0;
    end
  end

  if (FIXED_FB) begin : g_fixed
    assign fb = direct;
  end else begin : g_matrix
    assign fb = routed;
    // R5: with all state bits low, no routed feedback input can be high.
    p_route_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == '0) |-> (fb == '0));
  end

endmodule

// File: rtl/sop_state_bank.sv
module sop_state_bank #(
  parameter int N_ST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mode_wr,
  input  logic [N_ST-1:0]   mode_row,
  input  logic [2*N_ST-1:0] cols,
  output logic [N_ST-1:0]   st_q
);

  logic [N_ST-1:0] mode_q;
  logic [N_ST-1:0] j_vec;
  logic [N_ST-1:0] k_vec;
  logic [N_ST-1:0] jk_nxt;
  logic [N_ST-1:0] st_d;

  for (genvar i = 0; i < N_ST; i++) begin : g_pair
    assign j_vec[i] = cols[2*i];
    assign k_vec[i] = cols[2*i+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_row;
    end
  end

  always_comb begin
    jk_nxt = (j_vec & ~st_q) | (~k_vec & st_q);
    if (clr) begin
      st_d = '0;
    end else begin
      st_d = (mode_q & jk_nxt) | (~mode_q & j_vec);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  // R8: clear empties the state at the next edge.
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st_q == '0));

  // R6: D-mode bits take their data column.
  p_dload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((st_q & ~$past(mode_q)) == ($past(j_vec) & ~$past(mode_q))));

  // R7: J-K bits with both inputs low keep their value.
  p_jkhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (((st_q ^ $past(st_q)) & $past(mode_q & ~j_vec & ~k_vec)) == '0));

  // R7: J-K bits with both inputs high invert.
  p_jktoggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (((st_q ^ $past(st_q)) & $past(mode_q & j_vec & k_vec)) ==
              $past(mode_q & j_vec & k_vec)));

endmodule

// File: rtl/sop_seq_array.sv
module sop_seq_array
  import sop_pkg::*;
#(
  parameter int N_IN     = 4,
  parameter int N_OUT    = 4,
  parameter int N_ST     = 4,
  parameter int N_FBIN   = 4,
  parameter int N_TERM   = 12,
  parameter bit FIXED_FB = 1'b0,
  localparam int N_VAR   = N_IN + N_FBIN,
  localparam int N_OR    = N_OUT + 2 * N_ST,
  localparam int AW      = $clog2((N_TERM > N_FBIN) ? N_TERM : N_FBIN),
  localparam int DW      = max3(2 * N_VAR, N_OR, N_ST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data
);

  plane_e              plane;
  logic                we_and;
  logic                we_or;
  logic                we_route;
  logic                we_mode;
  logic [N_FBIN-1:0]   fb;
  logic [N_VAR-1:0]    vars;
  logic [N_TERM-1:0]   terms;
  logic [N_OR-1:0]     cols;
  logic [N_ST-1:0]     st_q;

  assign plane    = plane_e'(wr_sel);
  assign we_and   = wr_en && (plane == PL_AND);
  assign we_or    = wr_en && (plane == PL_OR);
  assign we_route = wr_en && (plane == PL_ROUTE);
  assign we_mode  = wr_en && (plane == PL_MODE);

  assign vars = {fb, din};

  sop_and_plane #(.N_VAR(N_VAR), .N_TERM(N_TERM), .AW(AW)) u_and (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (we_and),
    .wr_addr (wr_addr),
    .wr_row  (wr_data[2*N_VAR-1:0]),
    .vars    (vars),
    .terms   (terms)
  );

  sop_or_plane #(.N_TERM(N_TERM), .N_OR(N_OR), .AW(AW)) u_or (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (we_or),
    .wr_addr (wr_addr),
    .wr_row  (wr_data[N_OR-1:0]),
    .terms   (terms),
    .cols    (cols)
  );

  sop_state_bank #(.N_ST(N_ST)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .mode_wr  (we_mode),
    .mode_row (wr_data[N_ST-1:0]),
    .cols     (cols[N_OR-1:N_OUT]),
    .st_q     (st_q)
  );

  sop_fb_route #(.N_ST(N_ST), .N_FBIN(N_FBIN), .FIXED_FB(FIXED_FB), .AW(AW)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (we_route),
    .wr_addr (wr_addr),
    .wr_row  (wr_data[N_ST-1:0]),
    .st      (st_q),
    .fb      (fb)
  );

  assign dout = cols[N_OUT-1:0];

  // R1: the first cycle after reset release shows an empty array.
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dout == '0));

endmodule

// File: tb/sop_seq_array_bench.sv
module sop_seq_array_bench;

  localparam int NI = 4;
  localparam int NO = 4;
  localparam int NS = 4;
  localparam int NF = 4;
  localparam int NT = 12;

  logic        clk;
  logic        rst_n;
  logic        clr_a, clr_b;
  logic [3:0]  din_a, din_b;
  logic [3:0]  dout_a, dout_b;
  logic        wr_en_a, wr_en_b;
  logic [1:0]  wr_sel_a, wr_sel_b;
  logic [3:0]  wr_addr_a, wr_addr_b;
  logic [15:0] wr_data_a, wr_data_b;

  int n_chk;
  int n_bad;
  bit done;

  sop_seq_array #(.N_IN(NI), .N_OUT(NO), .N_ST(NS), .N_FBIN(NF), .N_TERM(NT),
                  .FIXED_FB(1'b0)) u_sop_seq_array (
    .clk(clk), .rst_n(rst_n), .clr(clr_a), .din(din_a), .dout(dout_a),
    .wr_en(wr_en_a), .wr_sel(wr_sel_a), .wr_addr(wr_addr_a), .wr_data(wr_data_a)
  );

  sop_seq_array #(.N_IN(NI), .N_OUT(NO), .N_ST(NS), .N_FBIN(NF), .N_TERM(NT),
                  .FIXED_FB(1'b1)) u_sop_seq_array_fix (
    .clk(clk), .rst_n(rst_n), .clr(clr_b), .din(din_b), .dout(dout_b),
    .wr_en(wr_en_b), .wr_sel(wr_sel_b), .wr_addr(wr_addr_b), .wr_data(wr_data_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Literal codes (R2): bit0 true line, bit1 complement line.
  localparam logic [1:0] L_T  = 2'b01;
  localparam logic [1:0] L_C  = 2'b10;
  localparam logic [1:0] L_DC = 2'b11;
  localparam logic [1:0] L_IN = 2'b00;

  function automatic logic [15:0] arow(input int v1, input logic [1:0] c1,
                                       input int v2, input logic [1:0] c2);
    logic [15:0] r;
    r = '1;
    if (v1 >= 0) r[2*v1 +: 2] = c1;
    if (v2 >= 0) r[2*v2 +: 2] = c2;
    return r;
  endfunction

  function automatic logic [15:0] col(input int c);
    return 16'(1) << c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [1:0] s, input int a, input logic [15:0] d);
    wr_en_a = 1'b1; wr_sel_a = s; wr_addr_a = 4'(a); wr_data_a = d;
    @(negedge clk);
    wr_en_a = 1'b0;
  endtask

  task automatic wr_b(input logic [1:0] s, input int a, input logic [15:0] d);
    wr_en_b = 1'b1; wr_sel_b = s; wr_addr_b = 4'(a); wr_data_b = d;
    @(negedge clk);
    wr_en_b = 1'b0;
  endtask

  task automatic clear_a();
    for (int t = 0; t < NT; t++) begin
      wr_a(2'd0, t, 16'h0);
      wr_a(2'd1, t, 16'h0);
    end
    for (int j = 0; j < NF; j++) wr_a(2'd2, j, 16'h0);
    wr_a(2'd3, 0, 16'h0);
    clr_a = 1'b1;
    @(negedge clk);
    clr_a = 1'b0;
  endtask

  task automatic t_reset();
    din_a = 4'hF;
    #1;
    chk("R1 outputs zero after reset, din=F", 32'(dout_a), 32'h0);
    din_a = 4'h0;
    #1;
    chk("R1 outputs zero after reset, din=0", 32'(dout_a), 32'h0);
  endtask

  task automatic t_literals();
    clear_a();
    // term0 = x0 & ~x1 ; term1 inhibited through x2 ; term2 all ignored
    wr_a(2'd0, 0, arow(0, L_T, 1, L_C));
    wr_a(2'd0, 1, arow(2, L_IN, -1, L_DC));
    wr_a(2'd0, 2, arow(-1, L_DC, -1, L_DC));
    wr_a(2'd0, 3, arow(2, L_T, -1, L_DC));
    wr_a(2'd0, 4, arow(3, L_T, -1, L_DC));
    din_a = 4'b0001;
    // R4: write staged, not yet clocked -> old value
    wr_en_a = 1'b1; wr_sel_a = 2'd1; wr_addr_a = 4'd0; wr_data_a = col(0);
    #1;
    chk("R4 OR row not active before write edge", 32'(dout_a[0]), 32'h0);
    @(negedge clk);
    wr_en_a = 1'b0;
    chk("R4 OR row active after write edge", 32'(dout_a[0]), 32'h1);
    wr_a(2'd1, 1, col(1));
    wr_a(2'd1, 2, col(2));
    wr_a(2'd1, 3, col(3));
    wr_a(2'd1, 4, col(3));
    din_a = 4'b0011; #1;
    chk("R2 complement literal blocks x1=1", 32'(dout_a[0]), 32'h0);
    din_a = 4'b0000; #1;
    chk("R2 true literal blocks x0=0", 32'(dout_a[0]), 32'h0);
    din_a = 4'b0101; #1;
    chk("R2 inhibit code 00 keeps term low", 32'(dout_a[1]), 32'h0);
    chk("R2 all-ignored term is high", 32'(dout_a[2]), 32'h1);
    chk("R3 column ORs term3 (x2)", 32'(dout_a[3]), 32'h1);
    din_a = 4'b1000; #1;
    chk("R3 column ORs term4 (x3)", 32'(dout_a[3]), 32'h1);
    din_a = 4'b0010; #1;
    chk("R3 column low with no active term", 32'(dout_a[3]), 32'h0);
    @(negedge clk);
  endtask

  task automatic t_dtoggle();
    clear_a();
    din_a = 4'h0;
    wr_a(2'd0, 0, arow(NI + 0, L_C, -1, L_DC));   // ~fb0
    wr_a(2'd1, 0, col(NO + 0));                    // D0
    wr_a(2'd0, 1, arow(NI + 0, L_T, -1, L_DC));   // fb0
    wr_a(2'd1, 1, col(0));                         // dout0
    wr_a(2'd2, 0, 16'h0001);                       // fb0 <- st0
    clr_a = 1'b1;
    @(negedge clk);
    clr_a = 1'b0;
    for (int n = 0; n < 4; n++) begin
      chk("R6 D-mode toggler sequence", 32'(dout_a[0]), 32'(n % 2));
      @(negedge clk);
    end
    // R5: disconnect routing row 0 -> feedback input reads zero
    wr_a(2'd2, 0, 16'h0000);
    chk("R5 empty routing row gives zero", 32'(dout_a[0]), 32'h0);
    @(negedge clk);
    chk("R5 empty routing row stays zero", 32'(dout_a[0]), 32'h0);
    // st1 forced to 1 by an all-ignored term into D1, fb0 = st0 | st1
    wr_a(2'd0, 2, arow(-1, L_DC, -1, L_DC));
    wr_a(2'd1, 2, col(NO + 2));
    wr_a(2'd2, 0, 16'h0003);
    @(negedge clk);
    chk("R5 routing row ORs two state bits", 32'(dout_a[0]), 32'h1);
    @(negedge clk);
    chk("R5 routing OR holds while st0 falls", 32'(dout_a[0]), 32'h1);
  endtask

  task automatic jk_step(input logic j, input logic k, input logic exp, input string msg);
    din_a = {2'b00, k, j};
    @(negedge clk);
    chk(msg, 32'(dout_a[1]), 32'(exp));
  endtask

  task automatic t_jk();
    clear_a();
    din_a = 4'h0;
    wr_a(2'd0, 0, arow(0, L_T, -1, L_DC));
    wr_a(2'd1, 0, col(NO + 2));                    // J1
    wr_a(2'd0, 1, arow(1, L_T, -1, L_DC));
    wr_a(2'd1, 1, col(NO + 3));                    // K1
    wr_a(2'd0, 2, arow(NI + 1, L_T, -1, L_DC));
    wr_a(2'd1, 2, col(1));                         // dout1 = fb1
    wr_a(2'd2, 1, 16'h0002);                       // fb1 <- st1
    wr_a(2'd3, 0, 16'h0002);                       // bit1 J-K
    clr_a = 1'b1;
    @(negedge clk);
    clr_a = 1'b0;
    chk("R7 J-K bit starts cleared", 32'(dout_a[1]), 32'h0);
    jk_step(1'b1, 1'b0, 1'b1, "R7 J=1 K=0 sets");
    jk_step(1'b0, 1'b0, 1'b1, "R7 J=0 K=0 holds one");
    jk_step(1'b0, 1'b0, 1'b1, "R7 J=0 K=0 holds one again");
    jk_step(1'b0, 1'b1, 1'b0, "R7 J=0 K=1 clears");
    jk_step(1'b0, 1'b0, 1'b0, "R7 J=0 K=0 holds zero");
    jk_step(1'b1, 1'b1, 1'b1, "R7 J=1 K=1 toggles up");
    jk_step(1'b1, 1'b1, 1'b0, "R7 J=1 K=1 toggles down");
    jk_step(1'b1, 1'b0, 1'b1, "R7 set before clear");
  endtask

  task automatic t_clear();
    din_a = 4'h0;
    clr_a = 1'b1;
    @(negedge clk);
    clr_a = 1'b0;
    chk("R8 clear empties state", 32'(dout_a[1]), 32'h0);
    jk_step(1'b1, 1'b0, 1'b1, "R8 personality kept after clear");
  endtask

  task automatic t_fixed();
    din_b = 4'h0;
    wr_b(2'd0, 0, arow(0, L_T, -1, L_DC));
    wr_b(2'd1, 0, col(NO + 0));                    // D0 = x0
    wr_b(2'd0, 1, arow(NI + 0, L_T, -1, L_DC));
    wr_b(2'd1, 1, col(0));                         // dout0 = fb0
    wr_b(2'd2, 0, 16'h0000);                       // ignored in fixed build
    chk("R9 fixed feedback low with state low", 32'(dout_b[0]), 32'h0);
    din_b = 4'b0001;
    @(negedge clk);
    chk("R9 fixed feedback carries st0 despite empty routing row", 32'(dout_b[0]), 32'h1);
    din_b = 4'b0000;
    @(negedge clk);
    chk("R9 fixed feedback follows st0 back to zero", 32'(dout_b[0]), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    clr_a = 1'b0; clr_b = 1'b0;
    din_a = '0; din_b = '0;
    wr_en_a = 1'b0; wr_en_b = 1'b0;
    wr_sel_a = '0; wr_sel_b = '0;
    wr_addr_a = '0; wr_addr_b = '0;
    wr_data_a = '0; wr_data_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_literals();
    t_dtoggle();
    t_jk();
    t_clear();
    t_fixed();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule